// File: doc/BRIEF.md
# Circular Audio DMA Engine

This block moves two 1-bit serial audio streams between a codec and system memory without processor involvement once it is started. An input stream is gathered bit by bit, packed into 32-bit words and written to a receive ring. A transmit stream is fetched word by word from a second ring and shifted out one bit at a time. Both rings share one length register. A countdown of remaining bits marks progress. When the countdown expires, both rings restart at their first word, so the engine runs until software stops it.

Software sees a small register window that repeats every 32 bytes. A 16-bit control word selects which directions run, whether the transmit line is muted, and whether received words are also copied into the transmit ring (pass-through). Two control bits pick one of three bit rates. The engine produces its own bit strobe from the clock, and the codec exchanges one bit in each direction on every strobe.

Top module: `audio_ring_dma`

## Requirements
- R1: Registers decode on the low five address bits only, so the register set repeats every 32 bytes: offset 0x00 holds the 16-bit control word, 0x10 the receive ring base, 0x14 the transmit ring base, 0x18 the 16-bit shared length in 8-byte units (only its low 10 bits count), and 0x0E reads the bit countdown.
- R2: Offset 0x08 always reads 0x00400002, offset 0x1C always reads 0x00000200, and unmapped offsets such as 0x04 read zero.
- R3: Control bit 7 enables the receive direction and bit 8 the transmit direction. The engine runs only while at least one of them is set and the length is nonzero; otherwise no bit strobe occurs.
- R4: The rate field formed by control bits {11,9} sets the bit strobe period: 2'b10 gives 4 clocks, 2'b01 gives 8 clocks, 2'b00 gives 9 clocks, and 2'b11 behaves as 2'b10.
- R5: With receive enabled, ser_in is sampled on each strobe and packed first bit into bit 31. On the 32nd bit of word k, that word is written to receive base + 4k.
- R6: With transmit enabled, word k is read from transmit base + 4k and shifted out bit 31 first. Read data returns on mem_rd_data one clock after the request. ser_out takes its new bit in the clock after each strobe.
- R7: While control bit 2 is clear, ser_out stays low even when transmit is running.
- R8: With pass-through (bit 6) and receive both set, every received word is also written to transmit base + 4k in the clock after its receive-ring write.
- R9: On start the countdown loads length x 64. It drops by one on each strobe and reads zero while idle. A new length takes effect only at the next reload.
- R10: After length x 64 bits the countdown reloads and both rings continue from word 0.
- R11: Writing 0x0000 to the control word stops the engine: no memory request is issued later than one clock after that write, the countdown reads zero, and a later start begins at word 0 of each ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| mem_wr_en | output | 1 | Memory word write request |
| mem_wr_addr | output | MA_W | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data |
| mem_rd_en | output | 1 | Memory word read request |
| mem_rd_addr | output | MA_W | Memory read byte address |
| mem_rd_data | input | 32 | Read data, valid one clock after the request |
| bit_strobe | output | 1 | One-clock pulse per serial bit |
| ser_in | input | 1 | Serial receive data from the codec |
| ser_out | output | 1 | Serial transmit data to the codec |

## Verification
The assertions follow the countdown on every cycle. They check that it holds between strobes, falls by exactly one per strobe, and wraps both the ring offset and the count at expiry. They also check that strobes are never back to back, that no memory request appears once the engine has been idle for a clock, and that the fixed status word reads correctly. Only the bench scenarios show that data is right end to end. These cover the bit order inside packed and unpacked words, the ring addresses across a wrap, the duplicate pass-through writes, muting, the measured strobe period for each rate code, the deferred length change, and a restart from word 0 after a halt.

// File: rtl/audio_ring_dma.sv
module audio_ring_dma #(
  parameter int RA_W     = 8,
  parameter int MA_W     = 32,
  parameter int CNT_W    = 16,
  parameter int DIV_FAST = 4,
  parameter int DIV_MID  = 8,
  parameter int DIV_SLOW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_wr_en,
  output logic [MA_W-1:0]   mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              mem_rd_en,
  output logic [MA_W-1:0]   mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              bit_strobe,
  input  logic              ser_in,
  output logic              ser_out
);
  localparam int LEN_EFF = CNT_W - 6;
  localparam int WOFF_W  = LEN_EFF + 1;
  localparam int DIV_MAX = (DIV_SLOW > DIV_MID) ? ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST)
                                                : ((DIV_MID > DIV_FAST) ? DIV_MID : DIV_FAST);
  localparam int DIV_W   = $clog2(DIV_MAX + 1);

  logic [15:0]       ctl_q, len_q;
  logic [MA_W-1:0]   in_base_q, out_base_q;
  logic              running_q, rd_pend_q, pt_pend_q, ser_q;
  logic [DIV_W-1:0]  div_q, div_lim;
  logic [4:0]        bit_idx_q;
  logic [WOFF_W-1:0] woff_q, next_woff;
  logic [CNT_W-1:0]  bits_q, reload;
  logic [31:0]       in_sh_q, out_sh_q, out_nxt_q, in_word, pt_data_q;
  logic [MA_W-1:0]   pt_addr_q;
  logic              run, strobe, last_bit;
  logic              unused_bits;

  assign run       = (ctl_q[7] | ctl_q[8]) && (len_q[LEN_EFF-1:0] != '0);
  assign reload    = {len_q[LEN_EFF-1:0], 6'b0};
  assign last_bit  = (bits_q == CNT_W'(1));
  assign next_woff = last_bit ? '0 : woff_q + WOFF_W'(1);
  assign in_word   = {in_sh_q[30:0], ser_in};
  assign strobe    = running_q && run && (div_q >= div_lim - DIV_W'(1));
  assign bit_strobe = strobe;
  assign ser_out   = ser_q & ctl_q[2] & ctl_q[8] & running_q;
  assign unused_bits = ^{reg_addr[RA_W-1:5], len_q[15:LEN_EFF]};

  always_comb begin
    case ({ctl_q[11], ctl_q[9]})
      2'b01:   div_lim = DIV_W'(DIV_MID);
      2'b00:   div_lim = DIV_W'(DIV_SLOW);
      default: div_lim = DIV_W'(DIV_FAST);
    endcase
  end

  always_comb begin
    case (reg_addr[4:0])
      5'h00:   reg_rdata = {16'h0, ctl_q};
      5'h08:   reg_rdata = 32'h0040_0002;
      5'h0E:   reg_rdata = 32'(bits_q);
      5'h10:   reg_rdata = 32'(in_base_q);
      5'h14:   reg_rdata = 32'(out_base_q);
      5'h18:   reg_rdata = {16'h0, len_q};
      5'h1C:   reg_rdata = 32'h0000_0200;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= '0;
      len_q      <= '0;
      in_base_q  <= '0;
      out_base_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr[4:0])
        5'h00: ctl_q      <= reg_wdata[15:0];
        5'h10: in_base_q  <= MA_W'(reg_wdata);
        5'h14: out_base_q <= MA_W'(reg_wdata);
        5'h18: len_q      <= reg_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running_q   <= 1'b0;
      div_q       <= '0;
      bit_idx_q   <= '0;
      woff_q      <= '0;
      bits_q      <= '0;
      in_sh_q     <= '0;
      out_sh_q    <= '0;
      out_nxt_q   <= '0;
      rd_pend_q   <= 1'b0;
      pt_pend_q   <= 1'b0;
      pt_addr_q   <= '0;
      pt_data_q   <= '0;
      ser_q       <= 1'b0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      mem_wr_en <= 1'b0;
      mem_rd_en <= 1'b0;
      rd_pend_q <= mem_rd_en;
      if (rd_pend_q) out_nxt_q <= mem_rd_data;

      if (!run) begin
        running_q <= 1'b0;
        div_q     <= '0;
        bit_idx_q <= '0;
        woff_q    <= '0;
        bits_q    <= '0;
        pt_pend_q <= 1'b0;
        ser_q     <= 1'b0;
      end else if (!running_q) begin
        running_q <= 1'b1;
        bits_q    <= reload;
        div_q     <= '0;
        bit_idx_q <= '0;
        woff_q    <= '0;
        if (ctl_q[8]) begin
          mem_rd_en   <= 1'b1;
          mem_rd_addr <= out_base_q;
        end
      end else begin
        div_q <= strobe ? '0 : div_q + DIV_W'(1);
        if (pt_pend_q) begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= pt_addr_q;
          mem_wr_data <= pt_data_q;
          pt_pend_q   <= 1'b0;
        end
        if (strobe) begin
          bits_q    <= last_bit ? reload : bits_q - CNT_W'(1);
          bit_idx_q <= bit_idx_q + 5'd1;
          in_sh_q   <= in_word;
          if (bit_idx_q == 5'd0) begin
            ser_q    <= out_nxt_q[31];
            out_sh_q <= {out_nxt_q[30:0], 1'b0};
          end else begin
            ser_q    <= out_sh_q[31];
            out_sh_q <= {out_sh_q[30:0], 1'b0};
          end
          if (bit_idx_q == 5'd31) begin
            woff_q <= next_woff;
            if (ctl_q[7]) begin
              mem_wr_en   <= 1'b1;
              mem_wr_addr <= in_base_q + MA_W'({woff_q, 2'b00});
              mem_wr_data <= in_word;
              if (ctl_q[6]) begin
                pt_pend_q <= 1'b1;
                pt_addr_q <= out_base_q + MA_W'({woff_q, 2'b00});
                pt_data_q <= in_word;
              end
            end
            if (ctl_q[8]) begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= out_base_q + MA_W'({next_woff, 2'b00});
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/audio_ring_dma_chk.sv
module audio_ring_dma_chk #(
  parameter int RA_W   = 8,
  parameter int CNT_W  = 16,
  parameter int WOFF_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              running_q,
  input logic              strobe,
  input logic [CNT_W-1:0]  bits_q,
  input logic [WOFF_W-1:0] woff_q,
  input logic              mem_wr_en,
  input logic              mem_rd_en,
  input logic [RA_W-1:0]   reg_addr,
  input logic [31:0]       reg_rdata
);
  p_status_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[4:0] == 5'h08) |-> (reg_rdata == 32'h0040_0002));

  p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && $past(strobe) && $past(bits_q) != CNT_W'(1))
      |-> (bits_q == $past(bits_q) - CNT_W'(1)));

  p_count_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && !$past(strobe)) |-> $stable(bits_q));

  p_ring_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (running_q && $past(running_q) && $past(strobe) && $past(bits_q) == CNT_W'(1))
      |-> (woff_q == '0 && bits_q != '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_q && !$past(running_q)) |-> (!mem_wr_en && !mem_rd_en));

  p_strobe_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
endmodule

bind audio_ring_dma audio_ring_dma_chk #(.RA_W(RA_W), .CNT_W(CNT_W), .WOFF_W(WOFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .running_q(running_q), .strobe(strobe),
  .bits_q(bits_q), .woff_q(woff_q), .mem_wr_en(mem_wr_en), .mem_rd_en(mem_rd_en),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata)
);

// File: tb/sim_audio_ring_dma.sv
`timescale 1ns/1ps
module sim_audio_ring_dma;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_wr_en, mem_rd_en, bit_strobe, ser_out;
  logic [31:0] mem_wr_addr, mem_rd_addr, mem_wr_data, mem_rd_data;
  logic ser_in = 0;

  always #2 clk = ~clk;

  audio_ring_dma u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .bit_strobe(bit_strobe), .ser_in(ser_in), .ser_out(ser_out)
  );

  logic [31:0] mem [0:511];
  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[10:2]];
    if (mem_wr_en) mem[mem_wr_addr[10:2]] <= mem_wr_data;
  end

  typedef struct packed { logic [31:0] a; logic [31:0] d; } wr_t;
  wr_t wq[$];
  logic bq[$];
  int checks = 0, fails = 0, cyc = 0, sc = 0, sc0 = 0, last_s = 0, gap = 0;
  bit out_mon = 0, done = 0;

  function automatic logic pbit(int k);
    logic [31:0] h;
    h = k * 32'h9E37_79B1;
    return h[17] ^ h[5];
  endfunction

  function automatic logic [31:0] word_of(int k0);
    logic [31:0] w;
    for (int i = 0; i < 32; i++) w[31-i] = pbit(k0 + i);
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: serial stream, strobe timing, memory writes
  always @(negedge clk) begin
    cyc++;
    if (bit_strobe) begin
      if (out_mon && (sc - sc0) > 0 && bq.size() > 0) chk("R6/R7 ser_out bit", 32'(ser_out), 32'(bq.pop_front()));
      gap = cyc - last_s;
      last_s = cyc;
      ser_in = pbit(sc - sc0);
      sc++;
    end
    if (mem_wr_en) begin
      if (wq.size() == 0) chk("R5/R8/R11 unexpected write", mem_wr_addr, 32'hFFFF_FFFF);
      else begin
        wr_t e;
        e = wq.pop_front();
        chk("R5/R8 write addr", mem_wr_addr, e.a);
        chk("R5/R8 write data", mem_wr_data, e.d);
      end
    end
    if (cyc > 150000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic reg_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_rel(int n);
    do @(posedge clk); while ((sc - sc0) < n);
  endtask

  task automatic start(logic [15:0] c);
    sc0 = sc;
    reg_write(8'h00, {16'h0, c});
  endtask

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset ser_out", 32'(ser_out), 0);
    chk("R11 reset mem_wr_en", 32'(mem_wr_en), 0);
    reg_read(8'h00, v); chk("R1 reset control", v, 0);
    reg_read(8'h0E, v); chk("R9 reset countdown", v, 0);

    // R2 fixed words, R1 mirroring
    reg_read(8'h08, v); chk("R2 status 0x08", v, 32'h0040_0002);
    reg_read(8'h1C, v); chk("R2 status 0x1C", v, 32'h0000_0200);
    reg_read(8'h04, v); chk("R2 unmapped", v, 0);
    reg_read(8'hE8, v); chk("R1 mirrored status", v, 32'h0040_0002);
    reg_write(8'h30, 32'h1234_5670);
    reg_read(8'h10, v); chk("R1 mirrored base write", v, 32'h1234_5670);

    // R4 rate codes, transmit muted so no writes
    reg_write(8'h18, 1);
    reg_write(8'h14, 32'h300);
    start(16'h0900); wait_rel(4); chk("R4 code 10 period", gap, 4);
    reg_write(8'h00, 0); repeat (4) @(negedge clk);
    start(16'h0300); wait_rel(4); chk("R4 code 01 period", gap, 8);
    reg_write(8'h00, 0); repeat (4) @(negedge clk);
    start(16'h0100); wait_rel(4); chk("R4 code 00 period", gap, 9);
    reg_write(8'h00, 0); repeat (4) @(negedge clk);
    start(16'h0B00); wait_rel(4); chk("R4 code 11 period", gap, 4);
    reg_write(8'h00, 0); repeat (4) @(negedge clk);

    // R3 zero length never runs
    reg_write(8'h18, 0);
    start(16'h0880); repeat (40) @(negedge clk);
    chk("R3 no strobe at zero length", sc - sc0, 0);
    reg_read(8'h0E, v); chk("R3 countdown idle", v, 0);
    reg_write(8'h00, 0);

    // R5/R10 receive ring with wrap, R9 countdown
    reg_write(8'h18, 1);
    reg_write(8'h10, 32'h100);
    for (int j = 0; j < 4; j++) wq.push_back({32'h100 + 32'(4 * (j % 2)), word_of(32 * j)});
    start(16'h0880);
    @(negedge clk);
    reg_read(8'h0E, v); chk("R9 countdown load", v, 64);
    wait_rel(10); reg_read(8'h0E, v); chk("R9 countdown step", v, 54);
    wait_rel(128);
    reg_write(8'h00, 0);
    repeat (20) @(negedge clk);
    chk("R11 receive queue drained", wq.size(), 0);
    reg_read(8'h0E, v); chk("R11 countdown after halt", v, 0);

    // R8 pass-through
    reg_write(8'h14, 32'h200);
    for (int j = 0; j < 2; j++) begin
      wq.push_back({32'h100 + 32'(4 * j), word_of(32 * j)});
      wq.push_back({32'h200 + 32'(4 * j), word_of(32 * j)});
    end
    start(16'h08C0); wait_rel(64);
    reg_write(8'h00, 0); repeat (10) @(negedge clk);
    chk("R8 pass-through queue drained", wq.size(), 0);

    // R11 restart from word 0
    wq.push_back({32'h100, word_of(0)});
    start(16'h0880); wait_rel(32);
    reg_write(8'h00, 0); repeat (10) @(negedge clk);
    chk("R11 restart queue drained", wq.size(), 0);

    // R6 transmit unpacking with wrap
    mem[9'h0C0] = 32'hA5C3_0F81;
    mem[9'h0C1] = 32'h7E19_D240;
    reg_write(8'h14, 32'h300);
    for (int j = 0; j < 128; j++) begin
      logic [31:0] w;
      w = ((j / 32) % 2 == 0) ? 32'hA5C3_0F81 : 32'h7E19_D240;
      bq.push_back(w[31 - (j % 32)]);
    end
    out_mon = 1;
    start(16'h0904); wait_rel(129);
    out_mon = 0;
    reg_write(8'h00, 0); repeat (6) @(negedge clk);
    chk("R6 all bits compared", bq.size(), 0);

    // R7 mute
    for (int j = 0; j < 64; j++) bq.push_back(1'b0);
    out_mon = 1;
    start(16'h0900); wait_rel(65);
    out_mon = 0;
    reg_write(8'h00, 0); repeat (6) @(negedge clk);
    chk("R7 mute bits compared", bq.size(), 0);

    // R9 deferred length change, R10 reload
    reg_write(8'h18, 1);
    start(16'h0900);
    wait_rel(10); reg_read(8'h0E, v); chk("R9 before length change", v, 54);
    reg_write(8'h18, 2);
    wait_rel(20); reg_read(8'h0E, v); chk("R9 old length still counting", v, 44);
    wait_rel(64); reg_read(8'h0E, v); chk("R10 reload with new length", v, 128);
    wait_rel(70); reg_read(8'h0E, v); chk("R9 count after reload", v, 122);
    reg_write(8'h00, 0); repeat (6) @(negedge clk);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule